// File: doc/BRIEF.md
# ADC Offset and Gain Correction Stage

This block sits after a 12-bit analog-to-digital converter. It takes each raw code, shifts it by an offset coefficient and scales it by a gain coefficient. The corrected code is clamped to the 12-bit range. Each input sample is qualified by a valid strobe, and each output sample is qualified by its own valid strobe, two clock edges later.

Both coefficients are 14 bits wide. Software writes each one as a 6-bit upper part and an 8-bit lower part. A write to the upper part is held back until the lower part arrives, so a coefficient only ever changes as a whole.

After every reset a small loader fetches factory coefficients over a request/acknowledge port to non-volatile storage. The loader steps through these states in order: `LD_IDLE`, `LD_REQ_OFS`, `LD_WAIT_OFS`, `LD_REQ_GAIN`, `LD_WAIT_GAIN`, `LD_READY`. The transitions are:
- `LD_IDLE` moves to `LD_REQ_OFS` one cycle after reset.
- A request state always moves to its wait state on the next edge.
- `LD_WAIT_OFS` moves to `LD_REQ_GAIN` when an acknowledge arrives.
- `LD_WAIT_GAIN` moves to `LD_READY` when an acknowledge arrives.
- `LD_READY` holds until the next reset.

The datapath and the register port only operate in `LD_READY`.

Top module: `adc_trim_corrector`

## Requirements
- R1: While reset is asserted, `out_valid` and `nv_req` are low. After reset the block requests the offset coefficient first (`nv_sel`=0), then the gain coefficient (`nv_sel`=1). Each request is a one-cycle `nv_req` pulse, and each coefficient is taken from `nv_data` on the cycle `nv_ack` is high. No further requests are made.
- R2: Before both coefficients are loaded, input samples produce no output, and register writes are discarded. After loading, results use the loaded values.
- R3: A sample accepted with `in_valid` at a clock edge appears with `out_valid` exactly two edges later. Exactly one output is produced per accepted sample.
- R4: The offset coefficient is two's complement. The code shift it applies is floor(ofs×9/512), which spans −144..+143 codes. This shift is subtracted from the raw code, so a larger coefficient gives a lower output.
- R5: The gain coefficient is unsigned, with 0x2000 meaning unity. The result is floor((raw − shift) × gain / 8192).
- R6: A result below 0 is clamped to 0, and a result above 4095 is clamped to 4095.
- R7: `reg_sel` selects the target register: 0 is offset bits 7:0, 1 is offset bits 13:8 (taken from `reg_wdata[5:0]`), 2 is gain bits 7:0, and 3 is gain bits 13:8. A write to an upper part has no effect on results until the matching lower part is written. The lower-part write then installs {held upper, new lower} in one step.
- R8: A lower-part write with no fresh upper write reuses the last held upper part. After loading, the held upper part equals the loaded upper bits.
- R9: A sample accepted on the same edge as a coefficient commit is corrected with the coefficients from before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw sample strobe |
| in_raw | input | 12 | Raw converter code |
| out_valid | output | 1 | Corrected sample strobe |
| out_code | output | 12 | Corrected, clamped code |
| reg_wr | input | 1 | Coefficient register write strobe |
| reg_sel | input | 2 | Register select (see R7) |
| reg_wdata | input | 8 | Write data |
| nv_req | output | 1 | Request pulse to non-volatile storage |
| nv_sel | output | 1 | Requested coefficient: 0 offset, 1 gain |
| nv_ack | input | 1 | Storage data valid |
| nv_data | input | 14 | Stored coefficient value |

## Verification
The correction path is tried with the following input patterns, each aimed at a different fault:

- **Unity gain with offset at zero, maximum and minimum.** These separate errors in the offset sign from errors in its scaling.
- **Extreme offsets and the maximum gain.** These drive the result past both rails, so a missing clamp or a wrap-around shows up.
- **Upper-only writes, lower-only writes, and writes landing on the same edge as a sample.** These expose a coefficient that changes non-atomically, or one that is snapshotted on the wrong edge.
- **Random codes with random coefficient pairs.** These cover the product and shift arithmetic across the whole range.
- **Samples and writes issued during the load.** These show that nothing leaks out before the factory values are in place.

// File: rtl/adct_pkg.sv
`timescale 1ns/1ps
package adct_pkg;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_REQ_OFS,
        LD_WAIT_OFS,
        LD_REQ_GAIN,
        LD_WAIT_GAIN,
        LD_READY
    } ld_state_t;

    // coefficient index, also bit 1 of the register select
    localparam int CIDX_OFS  = 0;
    localparam int CIDX_GAIN = 1;
    localparam int NUM_COEF  = 2;

endpackage

// File: rtl/adct_nv_loader.sv
`timescale 1ns/1ps
module adct_nv_loader
    import adct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nv_ack,
    output logic       nv_req,
    output logic       nv_sel,
    output logic [1:0] load_en,
    output logic       ready
);

    ld_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:      state_d = LD_REQ_OFS;
            LD_REQ_OFS:   state_d = LD_WAIT_OFS;
            LD_WAIT_OFS:  if (nv_ack) state_d = LD_REQ_GAIN;
            LD_REQ_GAIN:  state_d = LD_WAIT_GAIN;
            LD_WAIT_GAIN: if (nv_ack) state_d = LD_READY;
            LD_READY:     state_d = LD_READY;
            default:      state_d = LD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        nv_req  = 1'b0;
        nv_sel  = 1'b0;
        load_en = 2'b00;
        ready   = 1'b0;
        unique case (state_q)
            LD_IDLE: ;
            LD_REQ_OFS: begin
                nv_req = 1'b1;
                nv_sel = 1'b0;
            end
            LD_WAIT_OFS: begin
                nv_sel = 1'b0;
                load_en[CIDX_OFS] = nv_ack;
            end
            LD_REQ_GAIN: begin
                nv_req = 1'b1;
                nv_sel = 1'b1;
            end
            LD_WAIT_GAIN: begin
                nv_sel = 1'b1;
                load_en[CIDX_GAIN] = nv_ack;
            end
            LD_READY: ready = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/adct_coef_regs.sv
`timescale 1ns/1ps
module adct_coef_regs
    import adct_pkg::*;
#(
    parameter int COEF_W = 14,
    parameter int LO_W   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ready,
    input  logic [NUM_COEF-1:0]              load_en,
    input  logic [COEF_W-1:0]                nv_data,
    input  logic                             reg_wr,
    input  logic [1:0]                       reg_sel,
    input  logic [LO_W-1:0]                  reg_wdata,
    output logic [NUM_COEF-1:0][COEF_W-1:0]  coef_q
);

    localparam int HI_W = COEF_W - LO_W;

    for (genvar gi = 0; gi < NUM_COEF; gi++) begin : g_coef
        localparam logic [1:0]        LO_SEL = 2'(gi * 2);
        localparam logic [1:0]        HI_SEL = 2'(gi * 2 + 1);
        localparam logic [COEF_W-1:0] RST_V  =
            (gi == CIDX_GAIN) ? COEF_W'(1 << (COEF_W - 1)) : '0;

        logic [HI_W-1:0] held_hi;
        logic            lo_hit, hi_hit;

        assign lo_hit = ready && reg_wr && (reg_sel == LO_SEL);
        assign hi_hit = ready && reg_wr && (reg_sel == HI_SEL);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                coef_q[gi] <= RST_V;
                held_hi    <= RST_V[COEF_W-1:LO_W];
            end else if (load_en[gi]) begin
                coef_q[gi] <= nv_data;
                held_hi    <= nv_data[COEF_W-1:LO_W];
            end else if (lo_hit) begin
                coef_q[gi] <= {held_hi, reg_wdata};
            end else if (hi_hit) begin
                held_hi    <= reg_wdata[HI_W-1:0];
            end
        end
    end

endmodule

// File: rtl/adct_datapath.sv
`timescale 1ns/1ps
module adct_datapath #(
    parameter int RAW_W     = 12,
    parameter int COEF_W    = 14,
    parameter int OFS_MUL   = 9,
    parameter int OFS_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [RAW_W-1:0]  raw,
    input  logic [COEF_W-1:0] ofs_coef,
    input  logic [COEF_W-1:0] gain_coef,
    output logic              out_valid,
    output logic [RAW_W-1:0]  out_code
);

    localparam int OSC_W  = COEF_W + 6;
    localparam int DIFF_W = RAW_W + 2;
    localparam int PROD_W = DIFF_W + COEF_W + 1;
    localparam int GSHIFT = COEF_W - 1;
    localparam logic signed [PROD_W-1:0] CODE_MAX = PROD_W'((1 << RAW_W) - 1);

    // stage 1: offset scaling and subtraction, gain snapshot
    logic signed [OSC_W-1:0]  ofs_ext, ofs_scaled, ofs_codes;
    logic signed [DIFF_W-1:0] diff_d;

    assign ofs_ext    = {{(OSC_W - COEF_W){ofs_coef[COEF_W-1]}}, ofs_coef};
    assign ofs_scaled = ofs_ext * $signed(OSC_W'(OFS_MUL));
    assign ofs_codes  = ofs_scaled >>> OFS_SHIFT;
    assign diff_d     = $signed({2'b00, raw}) - ofs_codes[DIFF_W-1:0];

    logic                     s1_valid;
    logic signed [DIFF_W-1:0] s1_diff;
    logic [COEF_W-1:0]        s1_gain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_diff  <= '0;
            s1_gain  <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_diff <= diff_d;
                s1_gain <= gain_coef;
            end
        end
    end

    // stage 2: gain multiply, rescale, clamp
    logic signed [PROD_W-1:0] prod, scaled;
    logic [RAW_W-1:0]         clamped;

    assign prod   = s1_diff * $signed({1'b0, s1_gain});
    assign scaled = prod >>> GSHIFT;

    always_comb begin
        if (scaled < 0)             clamped = '0;
        else if (scaled > CODE_MAX) clamped = '1;
        else                        clamped = scaled[RAW_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_code <= clamped;
        end
    end

endmodule

// File: rtl/adc_trim_corrector.sv
`timescale 1ns/1ps
module adc_trim_corrector
    import adct_pkg::*;
#(
    parameter int RAW_W     = 12,
    parameter int COEF_W    = 14,
    parameter int LO_W      = 8,
    parameter int OFS_MUL   = 9,
    parameter int OFS_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  in_raw,
    output logic              out_valid,
    output logic [RAW_W-1:0]  out_code,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [LO_W-1:0]   reg_wdata,
    output logic              nv_req,
    output logic              nv_sel,
    input  logic              nv_ack,
    input  logic [COEF_W-1:0] nv_data
);

    logic                            ld_ready;
    logic [NUM_COEF-1:0]             load_en;
    logic [NUM_COEF-1:0][COEF_W-1:0] coef_q;
    logic [COEF_W-1:0]               ofs_coef, gain_coef;

    adct_nv_loader u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .nv_ack  (nv_ack),
        .nv_req  (nv_req),
        .nv_sel  (nv_sel),
        .load_en (load_en),
        .ready   (ld_ready)
    );

    adct_coef_regs #(
        .COEF_W (COEF_W),
        .LO_W   (LO_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ld_ready),
        .load_en   (load_en),
        .nv_data   (nv_data),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .coef_q    (coef_q)
    );

    assign ofs_coef  = coef_q[CIDX_OFS];
    assign gain_coef = coef_q[CIDX_GAIN];

    adct_datapath #(
        .RAW_W     (RAW_W),
        .COEF_W    (COEF_W),
        .OFS_MUL   (OFS_MUL),
        .OFS_SHIFT (OFS_SHIFT)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (in_valid && ld_ready),
        .raw       (in_raw),
        .ofs_coef  (ofs_coef),
        .gain_coef (gain_coef),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

endmodule

// File: rtl/adct_checker.sv
`timescale 1ns/1ps
module adct_checker #(
    parameter int COEF_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic              nv_req,
    input logic              ld_ready,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [COEF_W-1:0] ofs_coef,
    input logic [COEF_W-1:0] gain_coef
);

    AST_NO_REQ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> !nv_req); // R1

    AST_NO_OUT_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ready |-> !out_valid); // R2

    AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ld_ready) |-> ##2 out_valid); // R3

    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && ld_ready, 2)); // R3

    AST_UPPER_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ready && reg_wr && reg_sel[0]) |=> ($stable(ofs_coef) && $stable(gain_coef))); // R7

endmodule

bind adc_trim_corrector adct_checker #(.COEF_W(COEF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .nv_req    (nv_req),
    .ld_ready  (ld_ready),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .ofs_coef  (ofs_coef),
    .gain_coef (gain_coef)
);

// File: tb/adc_trim_corrector_tb_top.sv
`timescale 1ns/1ps
module adc_trim_corrector_tb_top;

    localparam logic [13:0] FAC_OFS  = 14'h00E4;
    localparam logic [13:0] FAC_GAIN = 14'h2100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_raw = '0;
    logic        out_valid;
    logic [11:0] out_code;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        nv_req, nv_sel;
    logic        nv_ack = 1'b0;
    logic [13:0] nv_data = '0;

    always #4 clk = ~clk;

    adc_trim_corrector dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
        .out_valid(out_valid), .out_code(out_code), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .nv_req(nv_req),
        .nv_sel(nv_sel), .nv_ack(nv_ack), .nv_data(nv_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    bit          m_ready = 1'b0;
    logic [13:0] m_coef [2];
    logic [5:0]  m_held [2];
    bit          pv [2];
    logic [11:0] pd [2];
    string       pt [2];

    int nv_sels [4];
    int nv_count = 0;

    function automatic logic [11:0] expect_code(input logic [11:0] raw,
                                               input logic [13:0] ofs,
                                               input logic [13:0] gain);
        int  so, oc, diff;
        longint p, r;
        so   = ofs[13] ? int'(ofs) - 16384 : int'(ofs);
        oc   = (so * 9) >>> 9;
        diff = int'(raw) - oc;
        p    = longint'(diff) * longint'(gain);
        r    = p >>> 13;
        if (r < 0) return 12'd0;
        if (r > 4095) return 12'd4095;
        return r[11:0];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [11:0] raw, input bit wr,
                        input logic [1:0] sel, input logic [7:0] wd, input string tag);
        @(negedge clk);
        if (out_valid !== pv[1])
            check(0, pv[1] ? pt[1] : "R3", "out_valid", int'(out_valid), int'(pv[1]));
        else if (pv[1])
            check(out_code === pd[1], pt[1], "out_code", int'(out_code), int'(pd[1]));
        else
            check(1, "R3", "idle", 0, 0);
        pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
        pv[0] = v && m_ready;
        pd[0] = expect_code(raw, m_coef[0], m_coef[1]);
        pt[0] = tag;
        if (wr && m_ready) begin
            if (sel[0]) m_held[sel[1]] = wd[5:0];
            else        m_coef[sel[1]] = {m_held[sel[1]], wd};
        end
        in_valid  = v;
        in_raw    = raw;
        reg_wr    = wr;
        reg_sel   = sel;
        reg_wdata = wd;
    endtask

    task automatic sample(input logic [11:0] raw, input string tag);
        step(1'b1, raw, 1'b0, 2'd0, 8'd0, tag);
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [7:0] wd, input string tag);
        step(1'b0, 12'd0, 1'b1, sel, wd, tag);
    endtask

    task automatic wcoef(input bit idx, input logic [13:0] val, input string tag);
        wreg({idx, 1'b1}, {2'b00, val[13:8]}, tag);
        wreg({idx, 1'b0}, val[7:0], tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 12'd0, 1'b0, 2'd0, 8'd0, "R3");
    endtask

    // storage responder
    initial begin
        int cnt;
        bit sel_q;
        cnt = 0;
        sel_q = 1'b0;
        forever begin
            @(negedge clk);
            nv_ack = 1'b0;
            if (!rst_n) begin
                cnt = 0;
            end else if (nv_req) begin
                if (nv_count < 4) nv_sels[nv_count] = int'(nv_sel);
                nv_count++;
                sel_q = nv_sel;
                cnt = 3;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    nv_ack  = 1'b1;
                    nv_data = sel_q ? FAC_GAIN : FAC_OFS;
                end
            end
        end
    end

    // watchdog
    initial begin
        #1600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        pv[0] = 0; pv[1] = 0;
        m_coef[0] = FAC_OFS; m_coef[1] = FAC_GAIN;
        m_held[0] = FAC_OFS[13:8]; m_held[1] = FAC_GAIN[13:8];

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
            check(nv_req === 1'b0, "R1", "nv_req in reset", int'(nv_req), 0);
        end
        rst_n = 1'b1;

        // R2: samples and writes during load are dropped
        for (int i = 0; i < 6; i++) step(1'b1, 12'(100 * i + 7), 1'b0, 2'd0, 8'd0, "R2");
        step(1'b0, 12'd0, 1'b1, 2'd0, 8'h55, "R2");
        step(1'b0, 12'd0, 1'b1, 2'd3, 8'h3F, "R2");
        idle(30);
        m_ready = 1'b1;

        // R1: request order and count
        check(nv_count == 2, "R1", "request count", nv_count, 2);
        check(nv_sels[0] == 0, "R1", "first select", nv_sels[0], 0);
        check(nv_sels[1] == 1, "R1", "second select", nv_sels[1], 1);

        // R2: factory values in use
        sample(12'd1000, "R2");
        sample(12'd4000, "R2");
        idle(2);

        // R4 / R5: unity gain, offset sweep
        wcoef(1'b1, 14'h2000, "R5");
        wcoef(1'b0, 14'h0000, "R4");
        sample(12'd500, "R4");
        wcoef(1'b0, 14'h1FFF, "R4");
        sample(12'd500, "R4");
        wcoef(1'b0, 14'h2000, "R4");
        sample(12'd500, "R4");
        idle(2);

        // R6: clamping
        wcoef(1'b0, 14'h1FFF, "R6");
        sample(12'd100, "R6");
        sample(12'd0, "R6");
        wcoef(1'b0, 14'h2000, "R6");
        sample(12'd4095, "R6");
        wcoef(1'b0, 14'h0000, "R6");
        wcoef(1'b1, 14'h3FFF, "R6");
        sample(12'd3000, "R6");
        wcoef(1'b1, 14'h1000, "R5");
        sample(12'd3000, "R5");
        idle(2);

        // R7: upper write alone does not change results
        wcoef(1'b1, 14'h2000, "R7");
        wreg(2'd1, 8'h1F, "R7");
        sample(12'd500, "R7");
        sample(12'd500, "R7");
        wreg(2'd0, 8'hFF, "R7");
        sample(12'd500, "R7");
        // R8: lower-only write reuses held upper part
        wreg(2'd0, 8'h00, "R8");
        sample(12'd500, "R8");
        idle(2);

        // R9: commit on the same edge as a sample
        wreg(2'd3, 8'h3F, "R9");
        step(1'b1, 12'd2000, 1'b1, 2'd2, 8'hFF, "R9");
        sample(12'd2000, "R9");
        idle(2);

        // R5: random sweep with random coefficients
        for (int i = 0; i < 2000; i++) begin
            int k;
            k = $urandom_range(0, 15);
            if (k == 0) wcoef(1'($urandom_range(0, 1)), 14'($urandom), "R5");
            else if (k == 1) idle(1);
            else sample(12'($urandom), "R5");
        end
        idle(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule